// File: doc/BRIEF.md
# Flag-Setting Multi-Width Shift Unit

This block shifts an operand left or right by a variable count and reports the carry and zero flags that result. The operand can be a byte, a word or a double-word, chosen by a 2-bit size code. A double-word arrives as two 16-bit halves, low half and high half, and is returned in the same split form so that it can be written back to a register pair.

The shift count comes from one of two places. It can be a register value, of which only the low five bits are used. It can also be an immediate field, which is four bits wide for byte and word operands and five bits wide for double-words. Left shifts fill with zeros from the bottom. Right shifts fill with zeros from the top. Carry is the last bit that leaves the operand. Zero is set when the result, taken at the operand width, is all zeros.

Each accepted request produces one registered result one cycle later. With that result come a write-back enable and a mask that tells the flag storage outside the block which flags to clear. The size code 2 is reserved. It raises an illegal-operation output and suppresses the write-back.

Top module: `shift_flag_unit`

## Requirements
- R1: Size code 0 selects a byte, taken from op_lo[7:0] and returned in res_lo[7:0]. Code 1 selects a word in op_lo/res_lo. Code 3 selects a double-word formed as {op_hi, op_lo} and returned as {res_hi, res_lo}. For byte and word sizes, the operand bits above the width are ignored and the result bits above the width are 0.
- R2: When cnt_from_imm is 0, the count is reg_cnt[4:0]. Bits reg_cnt[7:5] have no effect.
- R3: When cnt_from_imm is 1, the count is imm_cnt[3:0] for byte and word sizes, and imm_cnt[4:0] for the double-word size.
- R4: sh_dir 0 is a left shift with zero fill. Carry is operand bit W-n, where W is the width and n the count, when 1 <= n <= W. Carry is 0 when n > W, and the result is then 0.
- R5: sh_dir 1 is a right shift with zero fill. Carry is operand bit n-1 when 1 <= n <= W, and 0 when n > W.
- R6: A count of 0 returns the operand unchanged with carry 0.
- R7: flag_z is 1 exactly when the width-masked result is zero.
- R8: Size code 2 is reserved. The result is marked illegal=1 and wr_en=0. {res_hi, res_lo} equals {op_hi, op_lo}, and carry, zero and clr_mask are all 0.
- R9: For a legal size, wr_en=1 and clr_mask=4'b1111. The mask bits are: bit0 carry, bit1 zero, bit2 negative, bit3 overflow.
- R10: The result appears with out_valid one clock after in_valid is sampled, one result per request, with back-to-back requests allowed. Reset drives out_valid, wr_en and illegal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| sh_dir | input | 1 | 0 shift left, 1 shift right |
| size | input | 2 | Operand size code |
| cnt_from_imm | input | 1 | Count source: 1 immediate, 0 register |
| reg_cnt | input | 8 | Register-sourced count |
| imm_cnt | input | 5 | Immediate count field |
| op_lo | input | 16 | Operand low half |
| op_hi | input | 16 | Operand high half (double-word only) |
| out_valid | output | 1 | Result present |
| res_lo | output | 16 | Result low half |
| res_hi | output | 16 | Result high half |
| flag_c | output | 1 | Carry: last bit shifted out |
| flag_z | output | 1 | Zero flag |
| wr_en | output | 1 | Write result and flags back |
| illegal | output | 1 | Reserved size code seen |
| clr_mask | output | 4 | Flags cleared by this operation |

## Verification
The bench drives single-bit operands placed next to the top bit and next to the bottom bit, so that the carry position can be told apart from a neighbouring bit. It uses counts of 0, of exactly the width and of more than the width, which separate the last-bit-out rule from a shift that only wraps around. Count sources carry set bits above the used field, and byte and word operands carry set bits above their width, which shows that the masking takes place. Random mixes of size, direction and source are sent back to back and with idle gaps, and a scoreboard checks them against a bit-by-bit shift model.

// File: rtl/shf_pkg.sv
// Shared encodings for the shift unit.
// Assumes: size codes are fixed by the instruction decode that drives the unit.
package shf_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_RSVD  = 2'd2,
        SZ_DWORD = 2'd3
    } size_e;

    localparam int NUM_FLAGS = 4;
    localparam logic [NUM_FLAGS-1:0] CLR_ALL = 4'b1111;
endpackage

// File: rtl/shf_count_sel.sv
// Picks the effective shift count from the register or immediate source.
// Assumes: the register count is masked, and the immediate width depends on size.
module shf_count_sel #(
    parameter int REG_W    = 8,
    parameter int CNT_W    = 5,
    parameter int NARROW_W = 4
) (
    input  logic             from_imm,
    input  logic             wide,
    input  logic [REG_W-1:0] reg_cnt,
    input  logic [CNT_W-1:0] imm_cnt,
    output logic [CNT_W-1:0] cnt
);
    // Select the source and mask it to the field width in use.
    always_comb begin
        if (!from_imm)
            cnt = reg_cnt[CNT_W-1:0];
        else if (wide)
            cnt = imm_cnt;
        else
            cnt = {{(CNT_W-NARROW_W){1'b0}}, imm_cnt[NARROW_W-1:0]};
    end
endmodule

// File: rtl/shf_lane.sv
// One fixed-width shifter lane. It returns the result, the last bit shifted out and zero.
// Assumes: the count may exceed the width; bits beyond the width shift out as zeros.
module shf_lane #(
    parameter int W     = 8,
    parameter int CNT_W = 5
) (
    input  logic [W-1:0]     opnd,
    input  logic [CNT_W-1:0] n,
    input  logic             dir_right,
    output logic [W-1:0]     res,
    output logic             carry,
    output logic             zero
);
    logic [W:0] ext_l;
    logic [W:0] ext_r;

    // Widen by one guard bit on the side the data leaves through.
    always_comb begin
        ext_l = {1'b0, opnd} << n;
        ext_r = {opnd, 1'b0} >> n;
    end

    // Pick the direction; the guard bit holds the carry.
    always_comb begin
        if (dir_right) begin
            res   = ext_r[W:1];
            carry = ext_r[0];
        end else begin
            res   = ext_l[W-1:0];
            carry = ext_l[W];
        end
        zero = (res == '0);
    end
endmodule

// File: rtl/shf_out_stage.sv
// Output register stage: captures one result per request and forms the write-back controls.
// Assumes: a new request may arrive every cycle; the held result is replaced only by a new one.
module shf_out_stage #(
    parameter int OPW   = 32,
    parameter int FLG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OPW-1:0]   d_res,
    input  logic             d_c,
    input  logic             d_z,
    input  logic             d_bad,
    output logic             out_valid,
    output logic [OPW-1:0]   q_res,
    output logic             q_c,
    output logic             q_z,
    output logic             q_bad,
    output logic             q_wr,
    output logic [FLG_W-1:0] q_clr
);
    logic bad_r;

    // Register the result and its status on every accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            q_res     <= '0;
            q_c       <= 1'b0;
            q_z       <= 1'b0;
            bad_r     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                q_res <= d_res;
                q_c   <= d_c;
                q_z   <= d_z;
                bad_r <= d_bad;
            end
        end
    end

    // Form the write-back controls from the registered status.
    always_comb begin
        q_bad = out_valid & bad_r;
        q_wr  = out_valid & ~bad_r;
        q_clr = q_wr ? shf_pkg::CLR_ALL : '0;
    end
endmodule

// File: rtl/shift_flag_unit.sv
// Top of the multi-width shift unit. There is one lane per legal width, selected by size.
// Assumes: the double-word operand is {op_hi, op_lo}; the reserved size passes the operand through.
module shift_flag_unit #(
    parameter int HALF_W = 16,
    parameter int REG_W  = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              sh_dir,
    input  logic [1:0]        size,
    input  logic              cnt_from_imm,
    input  logic [REG_W-1:0]  reg_cnt,
    input  logic [CNT_W-1:0]  imm_cnt,
    input  logic [HALF_W-1:0] op_lo,
    input  logic [HALF_W-1:0] op_hi,
    output logic              out_valid,
    output logic [HALF_W-1:0] res_lo,
    output logic [HALF_W-1:0] res_hi,
    output logic              flag_c,
    output logic              flag_z,
    output logic              wr_en,
    output logic              illegal,
    output logic [3:0]        clr_mask
);
    import shf_pkg::*;

    localparam int OPW     = 2 * HALF_W;
    localparam int BYTE_W  = HALF_W / 2;
    localparam int NLANES  = 3;

    logic [OPW-1:0]   full_op;
    logic [CNT_W-1:0] cnt;
    logic [OPW-1:0]   lane_res [NLANES];
    logic             lane_c   [NLANES];
    logic             lane_z   [NLANES];
    logic [OPW-1:0]   sel_res;
    logic             sel_c;
    logic             sel_z;
    logic             sel_bad;

    assign full_op = {op_hi, op_lo};

    shf_count_sel #(.REG_W(REG_W), .CNT_W(CNT_W), .NARROW_W(CNT_W-1)) u_cnt (
        .from_imm (cnt_from_imm),
        .wide     (size == SZ_DWORD),
        .reg_cnt  (reg_cnt),
        .imm_cnt  (imm_cnt),
        .cnt      (cnt)
    );

    // One lane per width: byte, word, double-word.
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam int LW = BYTE_W << g;
        logic [LW-1:0] r;
        shf_lane #(.W(LW), .CNT_W(CNT_W)) u_lane (
            .opnd      (full_op[LW-1:0]),
            .n         (cnt),
            .dir_right (sh_dir),
            .res       (r),
            .carry     (lane_c[g]),
            .zero      (lane_z[g])
        );
        assign lane_res[g] = OPW'(r);
    end

    // Route the lane chosen by size; the reserved code passes the operand through.
    always_comb begin
        sel_bad = 1'b0;
        unique case (size_e'(size))
            SZ_BYTE:  begin sel_res = lane_res[0]; sel_c = lane_c[0]; sel_z = lane_z[0]; end
            SZ_WORD:  begin sel_res = lane_res[1]; sel_c = lane_c[1]; sel_z = lane_z[1]; end
            SZ_DWORD: begin sel_res = lane_res[2]; sel_c = lane_c[2]; sel_z = lane_z[2]; end
            default:  begin sel_res = full_op; sel_c = 1'b0; sel_z = 1'b0; sel_bad = 1'b1; end
        endcase
    end

    logic [OPW-1:0] q_res;

    shf_out_stage #(.OPW(OPW), .FLG_W(NUM_FLAGS)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d_res     (sel_res),
        .d_c       (sel_c),
        .d_z       (sel_z),
        .d_bad     (sel_bad),
        .out_valid (out_valid),
        .q_res     (q_res),
        .q_c       (flag_c),
        .q_z       (flag_z),
        .q_bad     (illegal),
        .q_wr      (wr_en),
        .q_clr     (clr_mask)
    );

    assign res_lo = q_res[HALF_W-1:0];
    assign res_hi = q_res[OPW-1:HALF_W];
endmodule

// File: rtl/shf_checker.sv
// Property checker for shift_flag_unit, attached with bind.
// Assumes: the default widths (16-bit halves, 5-bit count).
module shf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  size,
    input logic        cnt_from_imm,
    input logic [7:0]  reg_cnt,
    input logic [15:0] op_lo,
    input logic [15:0] op_hi,
    input logic        out_valid,
    input logic [15:0] res_lo,
    input logic [15:0] res_hi,
    input logic        flag_c,
    input logic        flag_z,
    input logic        wr_en,
    input logic        illegal,
    input logic [3:0]  clr_mask
);
    assert_req_gives_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_result_has_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    assert_no_write_when_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_en);
    assert_rsvd_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(size) == 2'd2) |->
        (illegal && {res_hi, res_lo} == $past({op_hi, op_lo}) && !flag_c && !flag_z));
    assert_byte_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(size) == 2'd0) |-> (res_hi == 16'h0 && res_lo[15:8] == 8'h0));
    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (flag_z == ({res_hi, res_lo} == 32'h0)));
    assert_clear_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> clr_mask == 4'b1111);
    assert_no_clear_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> clr_mask == 4'b0000);
    assert_zero_count_no_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(!cnt_from_imm && reg_cnt[4:0] == 5'd0)) |-> !flag_c);
endmodule

bind shift_flag_unit shf_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .size         (size),
    .cnt_from_imm (cnt_from_imm),
    .reg_cnt      (reg_cnt),
    .op_lo        (op_lo),
    .op_hi        (op_hi),
    .out_valid    (out_valid),
    .res_lo       (res_lo),
    .res_hi       (res_hi),
    .flag_c       (flag_c),
    .flag_z       (flag_z),
    .wr_en        (wr_en),
    .illegal      (illegal),
    .clr_mask     (clr_mask)
);

// File: tb/sim_shift_flag_unit.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected results, and the monitor pops and compares them.
module sim_shift_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        sh_dir = 1'b0;
    logic [1:0]  size = 2'd0;
    logic        cnt_from_imm = 1'b0;
    logic [7:0]  reg_cnt = '0;
    logic [4:0]  imm_cnt = '0;
    logic [15:0] op_lo = '0;
    logic [15:0] op_hi = '0;
    logic        out_valid;
    logic [15:0] res_lo;
    logic [15:0] res_hi;
    logic        flag_c;
    logic        flag_z;
    logic        wr_en;
    logic        illegal;
    logic [3:0]  clr_mask;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [39:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    shift_flag_unit u0 (.*);

    // Bit-by-bit reference: {illegal, wr_en, clr[3:0], c, z, hi, lo}.
    function automatic logic [39:0] model(logic dir, logic [1:0] sz, logic [4:0] n, logic [31:0] op);
        int w;
        logic [63:0] mask;
        logic [31:0] v;
        logic c;
        if (sz == 2'd2) return {1'b1, 1'b0, 4'h0, 1'b0, 1'b0, op};
        w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        mask = (64'd1 << w) - 64'd1;
        v = op & mask[31:0];
        c = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (!dir) begin
                c = v[w-1];
                v = (v << 1) & mask[31:0];
            end else begin
                c = v[0];
                v = v >> 1;
            end
        end
        return {1'b0, 1'b1, 4'hF, c, (v == 32'h0), v};
    endfunction

    task automatic drive(input logic dir, input logic [1:0] sz, input logic imm,
                         input logic [7:0] rc, input logic [4:0] ic,
                         input logic [15:0] hi, input logic [15:0] lo, input string tag);
        logic [4:0] n;
        @(negedge clk);
        in_valid = 1'b1; sh_dir = dir; size = sz; cnt_from_imm = imm;
        reg_cnt = rc; imm_cnt = ic; op_hi = hi; op_lo = lo;
        n = !imm ? rc[4:0] : (sz == 2'd3 ? ic : {1'b0, ic[3:0]});
        exp_q.push_back(model(dir, sz, n, {hi, lo}));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare each result with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            logic [39:0] act;
            act = {illegal, wr_en, clr_mask, flag_c, flag_z, res_hi, res_lo};
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected result actual=%h expected=none", act);
            end else begin
                logic [39:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (act !== e) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", t, act, e);
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL R10 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || wr_en !== 1'b0 || illegal !== 1'b0) begin
            fails++;
            $display("FAIL R10 reset state actual=%b%b%b expected=000", out_valid, wr_en, illegal);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle(2);

        drive(0, 2'd0, 0, 8'd1,  5'd0, 16'h0000, 16'h0081, "R4 byte left carry top bit");
        drive(0, 2'd0, 0, 8'd1,  5'd0, 16'h0000, 16'h0080, "R7 byte left to zero");
        drive(0, 2'd0, 0, 8'd9,  5'd0, 16'h0000, 16'h00FF, "R4 byte left beyond width");
        drive(0, 2'd0, 0, 8'd8,  5'd0, 16'h0000, 16'h0001, "R4 byte left by width");
        drive(1, 2'd0, 0, 8'd1,  5'd0, 16'h0000, 16'h0003, "R5 byte right carry bit0");
        drive(1, 2'd0, 0, 8'd8,  5'd0, 16'h0000, 16'h0080, "R5 byte right by width");
        drive(1, 2'd0, 0, 8'd9,  5'd0, 16'h0000, 16'h00FF, "R5 byte right beyond width");
        drive(0, 2'd0, 0, 8'd1,  5'd0, 16'hFFFF, 16'hAB81, "R1 byte ignores upper bits");
        drive(0, 2'd1, 0, 8'd1,  5'd0, 16'h1234, 16'h8001, "R1 word left carry bit15");
        drive(1, 2'd3, 0, 8'd17, 5'd0, 16'h0001, 16'h0000, "R5 dword right carry bit16");
        drive(0, 2'd3, 0, 8'd31, 5'd0, 16'h0000, 16'h0003, "R4 dword left by 31");
        drive(0, 2'd3, 0, 8'd16, 5'd0, 16'h8000, 16'h0001, "R1 dword halves");
        drive(0, 2'd1, 0, 8'd0,  5'd0, 16'h0000, 16'hFFFF, "R6 count zero left");
        drive(1, 2'd3, 0, 8'h20, 5'd0, 16'h8000, 16'h0001, "R6 count zero right, R2 bit5");
        drive(0, 2'd0, 0, 8'hE1, 5'd0, 16'h0000, 16'h0041, "R2 reg upper bits ignored");
        drive(0, 2'd0, 1, 8'd0,  5'h11, 16'h0000, 16'h0041, "R3 narrow immediate");
        drive(1, 2'd3, 1, 8'd0,  5'h11, 16'h0003, 16'h0000, "R3 wide immediate");
        drive(0, 2'd2, 0, 8'd3,  5'd0, 16'hDEAD, 16'hBEEF, "R8 reserved size");
        drive(0, 2'd1, 1, 8'd0,  5'd4, 16'h0000, 16'h0F00, "R9 legal clears flags");
        idle(3);
        drive(1, 2'd1, 0, 8'd0,  5'd0, 16'h0000, 16'h0000, "R7 zero count zero operand");
        idle(1);

        for (int i = 0; i < 300; i++) begin
            drive($urandom_range(1, 0), 2'($urandom_range(3, 0)), $urandom_range(1, 0),
                  8'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), "R10 random mix");
            if ($urandom_range(3, 0) == 0) idle($urandom_range(2, 1));
        end
        idle(4);

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R10 results missing actual=%0d expected=0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule